// File: doc/BRIEF.md
# Z80 Machine-Cycle Stepper Controller

This block lets an operator walk a Z80 processor through a program one bus machine cycle at a time. It watches the processor's bus strobes. In step mode it pulls the active-low WAIT line on every memory or I/O access and keeps it low until the operator asks for the next cycle. A mode input turns stepping off entirely, so the processor runs at full speed. A hold-to-run button gives free running for as long as it is held. Two inputs request one step and are combined by OR: a push-button and a switch contact wired in parallel with it.

The same block produces the processor's reset. Reset comes from a level switch or from a momentary push-button. The reset pin is open-collector, so the block outputs a pull-down enable rather than a logic level. The buttons are synchronised to the Z80 clock and filtered with a stability counter of configurable length. A step request is cut down to a single-clock event on its press edge. All logic runs on the rising edge of the Z80 clock. A synchronous active-high block reset is provided.

Top module: `cycle_stepper`

## Requirements
- R1: With the free-run mode input high (after its two-flop synchroniser), `wait_n_o` stays high for every bus cycle.
- R2: In step mode, a qualifying access pulls `wait_n_o` low one clock edge after the strobes are seen. A qualifying access is MREQ low with RFSH high, or IORQ low together with RD, WR or M1 low. A refresh access (MREQ and RFSH both low) is never held.
- R3: A filtered press of the step request releases exactly one held cycle. Holding the button down does not release the following cycle. `wait_n_o` stays high until MREQ and IORQ are both inactive.
- R4: The step switch input is ORed with the step push-button and has the same effect.
- R5: While the filtered run button is held, cycles are not held. After release, the cycle already in progress completes without a hold, and the next qualifying access is held again.
- R6: The reset switch on (1) sets `cpu_rst_pull_o` to 1 within three clocks. Switch off with the button released sets it to 0.
- R7: The reset button asserts `cpu_rst_pull_o` while it is pressed and filtered. A press shorter than DEB_CYCLES clocks has no effect on `cpu_rst_pull_o`.
- R8: While CPU reset is asserted, `wait_n_o` is high and the stepper returns to idle. If an access is still pending after reset ends, that access is held again.
- R9: A step request made while no bus cycle is in progress is discarded. The next access is held.
- R10: While the block reset `rst` is high, `wait_n_o` is 1 and `cpu_rst_pull_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Z80 system clock |
| rst | input | 1 | Synchronous active-high block reset |
| free_mode_i | input | 1 | 1 = free run, 0 = single-step |
| mreq_n_i | input | 1 | Memory request strobe, active low |
| iorq_n_i | input | 1 | I/O request strobe, active low |
| m1_n_i | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| rfsh_n_i | input | 1 | Refresh indicator, active low |
| adv_btn_i | input | 1 | Step push-button, 1 = pressed |
| adv_sw_i | input | 1 | Step switch contact in parallel, 1 = closed |
| run_btn_i | input | 1 | Hold-to-run button, 1 = pressed |
| rst_sw_i | input | 1 | CPU reset level switch, 1 = on |
| rst_btn_i | input | 1 | CPU reset push-button, 1 = pressed |
| wait_n_o | output | 1 | WAIT to the CPU, active low |
| cpu_rst_pull_o | output | 1 | 1 = pull the open-collector CPU reset low |

## Verification
The bench builds the block with DEB_CYCLES = 4, not the default 50000. A filtered press therefore completes in a few clocks. At that length a glitch of two clocks falls just under the filter and tests rejection. Every hold, release and reset path then fits in a short run. This covers memory, I/O, interrupt-acknowledge and refresh accesses, a button held across two cycles, and reset arriving while a cycle is held.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_PASS = 2'd2
  } step_st_t;

  localparam int NUM_FILT = 3;
  localparam int F_ADV    = 0;
  localparam int F_RUN    = 1;
  localparam int F_RSTB   = 2;
endpackage

// File: rtl/stp_debounce.sv
module stp_debounce #(
  parameter int DEB_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          s0, s1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0      <= 1'b0;
      s1      <= 1'b0;
      cnt     <= '0;
      level_o <= 1'b0;
    end else begin
      s0 <= raw_i;
      s1 <= s0;
      if (s1 == level_o) begin
        cnt <= '0;
      end else if (cnt == CW'(DEB_CYCLES - 1)) begin
        level_o <= s1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stp_bus_decode.sv
module stp_bus_decode (
  input  logic mreq_n,
  input  logic iorq_n,
  input  logic m1_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic rfsh_n,
  output logic access
);
  logic mem_acc, io_acc;
  assign mem_acc = ~mreq_n & rfsh_n;
  assign io_acc  = ~iorq_n & (~rd_n | ~wr_n | ~m1_n);
  assign access  = mem_acc | io_acc;
endmodule

// File: rtl/stp_step_fsm.sv
module stp_step_fsm
  import stp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic access,
  input  logic free_run,
  input  logic adv_pulse,
  output logic wait_n
);
  step_st_t st, nx;

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE: if (access) nx = (free_run | adv_pulse) ? ST_PASS : ST_HOLD;
      ST_HOLD: if (free_run | adv_pulse) nx = ST_PASS;
      ST_PASS: if (!access) nx = ST_IDLE;
      default: nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) st <= ST_IDLE;
    else              st <= nx;
  end

  assign wait_n = (st != ST_HOLD);
endmodule

// File: rtl/cycle_stepper.sv
module cycle_stepper
  import stp_pkg::*;
#(
  parameter int DEB_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic free_mode_i,
  input  logic mreq_n_i,
  input  logic iorq_n_i,
  input  logic m1_n_i,
  input  logic rd_n_i,
  input  logic wr_n_i,
  input  logic rfsh_n_i,
  input  logic adv_btn_i,
  input  logic adv_sw_i,
  input  logic run_btn_i,
  input  logic rst_sw_i,
  input  logic rst_btn_i,
  output logic wait_n_o,
  output logic cpu_rst_pull_o
);
  logic [NUM_FILT-1:0] raw_btn, filt;
  logic [1:0]          lvl_s0, lvl_s1;
  logic                adv_prev, adv_pulse, free_run, cpu_rst_lvl, bus_access;

  assign raw_btn[F_ADV]  = adv_btn_i | adv_sw_i;
  assign raw_btn[F_RUN]  = run_btn_i;
  assign raw_btn[F_RSTB] = rst_btn_i;

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
    stp_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (raw_btn[i]),
      .level_o (filt[i])
    );
  end

  // bit 0: free-run mode, bit 1: reset level switch
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_s0   <= '0;
      lvl_s1   <= '0;
      adv_prev <= 1'b0;
    end else begin
      lvl_s0   <= {rst_sw_i, free_mode_i};
      lvl_s1   <= lvl_s0;
      adv_prev <= filt[F_ADV];
    end
  end

  assign adv_pulse   = filt[F_ADV] & ~adv_prev;
  assign free_run    = lvl_s1[0] | filt[F_RUN];
  assign cpu_rst_lvl = lvl_s1[1] | filt[F_RSTB];

  always_ff @(posedge clk) begin
    if (rst) cpu_rst_pull_o <= 1'b1;
    else     cpu_rst_pull_o <= cpu_rst_lvl;
  end

  stp_bus_decode u_dec (
    .mreq_n (mreq_n_i),
    .iorq_n (iorq_n_i),
    .m1_n   (m1_n_i),
    .rd_n   (rd_n_i),
    .wr_n   (wr_n_i),
    .rfsh_n (rfsh_n_i),
    .access (bus_access)
  );

  stp_step_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .clear     (cpu_rst_lvl),
    .access    (bus_access),
    .free_run  (free_run),
    .adv_pulse (adv_pulse),
    .wait_n    (wait_n_o)
  );
endmodule

// File: rtl/stp_checker.sv
module stp_checker (
  input logic clk,
  input logic rst,
  input logic wait_n,
  input logic rst_pull,
  input logic free_run,
  input logic access,
  input logic adv_pulse,
  input logic rst_lvl
);
  // R1, R5: free running never leaves a cycle held
  a_r1_free_no_hold: assert property (@(posedge clk) disable iff (rst)
    free_run |=> wait_n);

  // R2: WAIT only falls for a qualifying access
  a_r2_hold_needs_access: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_n) |-> $past(access));

  // R3: a held cycle is only released by a step, free running or CPU reset
  a_r3_release_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_n) |-> $past(adv_pulse | free_run | rst_lvl));

  // R8: CPU reset frees the bus
  a_r8_reset_frees_wait: assert property (@(posedge clk) disable iff (rst)
    rst_lvl |=> wait_n);

  // R6: the reset pull-down follows the reset request
  a_r6_pull_follows: assert property (@(posedge clk) disable iff (rst)
    rst_lvl |=> rst_pull);

  // R10: block reset state
  a_r10_block_reset: assert property (@(posedge clk)
    rst |=> (rst_pull && wait_n));
endmodule

bind cycle_stepper stp_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .wait_n    (wait_n_o),
  .rst_pull  (cpu_rst_pull_o),
  .free_run  (free_run),
  .access    (bus_access),
  .adv_pulse (adv_pulse),
  .rst_lvl   (cpu_rst_lvl)
);

// File: tb/sim_cycle_stepper.sv
`timescale 1ns/1ps
module sim_cycle_stepper;
  localparam int DEB = 4;
  localparam int SETTLE = DEB + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic free_mode = 1'b0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1;
  logic adv_btn = 1'b0, adv_sw = 1'b0, run_btn = 1'b0, rst_sw = 1'b0, rst_btn = 1'b0;
  logic wait_n, rst_pull;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cycle_stepper #(.DEB_CYCLES(DEB)) u0 (
    .clk(clk), .rst(rst), .free_mode_i(free_mode),
    .mreq_n_i(mreq_n), .iorq_n_i(iorq_n), .m1_n_i(m1_n),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .rfsh_n_i(rfsh_n),
    .adv_btn_i(adv_btn), .adv_sw_i(adv_sw), .run_btn_i(run_btn),
    .rst_sw_i(rst_sw), .rst_btn_i(rst_btn),
    .wait_n_o(wait_n), .cpu_rst_pull_o(rst_pull)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    mreq_n = 1'b1; iorq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rfsh_n = 1'b1;
    cyc(2);
  endtask

  task automatic mem_read();
    mreq_n = 1'b0; rd_n = 1'b0; rfsh_n = 1'b1;
  endtask

  task automatic step_once();
    adv_btn = 1'b1; cyc(SETTLE);
    adv_btn = 1'b0; cyc(SETTLE);
  endtask

  task automatic t_reset_state();
    cyc(3);
    chk("R10", "wait_n in reset", wait_n, 1'b1);
    chk("R10", "pull in reset", rst_pull, 1'b1);
    rst = 1'b0;
    cyc(4);
    chk("R6", "pull with switch off", rst_pull, 1'b0);
  endtask

  task automatic t_free_run();
    free_mode = 1'b1; cyc(4);
    mem_read();
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      chk("R1", "wait_n in free run", wait_n, 1'b1);
    end
    bus_idle();
    free_mode = 1'b0; cyc(4);
  endtask

  task automatic t_step_hold();
    mem_read(); cyc(2);
    chk("R2", "memory read held", wait_n, 1'b0);
    adv_btn = 1'b1; cyc(SETTLE);
    chk("R3", "released by step", wait_n, 1'b1);
    bus_idle();
    mem_read(); cyc(3);
    chk("R3", "next cycle held with button down", wait_n, 1'b0);
    adv_btn = 1'b0; cyc(SETTLE);
    chk("R3", "button release does not step", wait_n, 1'b0);
    adv_sw = 1'b1; cyc(SETTLE);
    chk("R4", "released by step switch", wait_n, 1'b1);
    bus_idle();
    adv_sw = 1'b0; cyc(SETTLE);
  endtask

  task automatic t_kinds();
    mreq_n = 1'b0; rfsh_n = 1'b0; cyc(3);
    chk("R2", "refresh not held", wait_n, 1'b1);
    bus_idle();
    iorq_n = 1'b0; wr_n = 1'b0; cyc(3);
    chk("R2", "I/O write held", wait_n, 1'b0);
    step_once();
    chk("R3", "I/O write released", wait_n, 1'b1);
    bus_idle();
    m1_n = 1'b0; iorq_n = 1'b0; cyc(3);
    chk("R2", "interrupt acknowledge held", wait_n, 1'b0);
    step_once();
    bus_idle();
  endtask

  task automatic t_idle_step();
    step_once();
    mem_read(); cyc(3);
    chk("R9", "idle step discarded, access held", wait_n, 1'b0);
    step_once();
    bus_idle();
  endtask

  task automatic t_run_button();
    run_btn = 1'b1; cyc(SETTLE);
    mem_read(); cyc(3);
    chk("R5", "not held while run pressed", wait_n, 1'b1);
    run_btn = 1'b0; cyc(SETTLE);
    chk("R5", "current cycle finishes after release", wait_n, 1'b1);
    bus_idle();
    mem_read(); cyc(3);
    chk("R5", "next cycle held after release", wait_n, 1'b0);
  endtask

  task automatic t_cpu_reset();
    // a cycle is held on entry
    rst_sw = 1'b1; cyc(4);
    chk("R6", "pull with switch on", rst_pull, 1'b1);
    chk("R8", "wait released in reset", wait_n, 1'b1);
    rst_sw = 1'b0; cyc(4);
    chk("R6", "pull after switch off", rst_pull, 1'b0);
    chk("R8", "pending access held again", wait_n, 1'b0);
    rst_btn = 1'b1; repeat (2) @(posedge clk); @(negedge clk);
    rst_btn = 1'b0;
    for (int i = 0; i < 10; i++) begin
      chk("R7", "short reset press ignored", rst_pull, 1'b0);
      cyc(1);
    end
    rst_btn = 1'b1; cyc(SETTLE);
    chk("R7", "pull while button held", rst_pull, 1'b1);
    chk("R8", "wait released by button reset", wait_n, 1'b1);
    rst_btn = 1'b0; cyc(SETTLE);
    chk("R7", "pull after button release", rst_pull, 1'b0);
    bus_idle();
  endtask

  initial begin
    t_reset_state();
    t_free_run();
    t_step_hold();
    t_kinds();
    t_idle_step();
    t_run_button();
    t_cpu_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule